// File: doc/BRIEF.md
# Program/Erase Status Word Generator

This block builds the byte that a flash device drives onto its data bus when the host reads it while an embedded program or erase is running, is suspended, or has just failed. The array engine itself is not modelled: it reports its mode through a small state code plus completion and failure pulses. The block turns those into a status word that software can poll. The word holds a complement-of-data poll bit, two toggle bits that behave differently, a sticky failure bit, and a bit that shows whether the erase-start window is still open. A ready/busy level is also produced.

The host reads by raising `rdStrobe` for one or more cycles while `rdBlk` selects a block. The first toggle bit advances once at the end of every read. The second advances only at the end of a read whose block is marked as being erased. Block-erase confirms and chip-erase commands fill the erase mask and restart a cycle-counted window. A reset command clears the mask, the window and the failure bit. In idle with no failure, and during a suspended erase on a block that is not erasing, the block passes the array data through.

Top module: `pe_status_poll`

## Requirements
- R1: With `opState` = 1 (program), the output is {~progMsb, t6, err, 0, win, 1, 0, 0}, with bit 7 first. t6 is the every-read toggle, err is the sticky failure bit, and win is 1 when no erase window is open. `ready` is low.
- R2: With `opState` = 2 (erase), bit 7 is 0 and bit 6 is t6. Bit 2 is the erase toggle t2 when `rdBlk` is in the erase mask and 1 otherwise. Bits 5 and 3 are err and win, and bits 4, 1 and 0 are 0. When `opDone` arrives in this state, the mask is cleared.
- R3: A `chipErase` pulse marks every block as erasing, so bit 2 toggles on reads of any block.
- R4: With `opState` = 3 (erase suspended), a read of a block in the mask returns {1, 1, err, 0, win, t2, 0, 0}. A read of any other block returns `arrayData`. `ready` is high.
- R5: With `opState` = 4 (program during suspend), the word has the same layout as in R1 and `ready` is low.
- R6: err is set by `opFail` and is shown in bit 5. It stays set until `resetCmd` or `opDone`, and `resetCmd` takes priority over `opFail`, which takes priority over `opDone`.
- R7: With `opState` = 0 and err set, reads return {0, t6, 1, 0, win, b2, 0, 0}. b2 is t2 when the block is in the (retained) mask and 1 otherwise. `resetCmd` restores array pass-through and clears the mask.
- R8: An `eraseConfirm` or `chipErase` adds blocks to the mask and makes win 0 from the next cycle for exactly WINDOW cycles. A further confirm restarts the full window.
- R9: t6 inverts once per read, on the first cycle after `rdStrobe` falls, so two back-to-back reads show opposite bit 6. t2 inverts at the same point only if the read's block was in the mask and `opState` is 2 or 3, or is 0 with err set. Neither changes while `rdStrobe` is high.
- R10: `ready` is low exactly when `opState` is 1, 2 or 4.
- R11: After reset, t6, t2, err and the mask are 0, win is 1, `ready` is high and the output equals `arrayData`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| opState | input | 3 | 0 idle, 1 program, 2 erase, 3 erase suspended, 4 program in suspend |
| rdStrobe | input | 1 | High while a read is in progress |
| rdBlk | input | BLK_W | Block-select part of the read address |
| eraseConfirm | input | 1 | Block-erase confirm pulse |
| eraseBlk | input | BLK_W | Block named by the confirm |
| chipErase | input | 1 | Whole-array erase command pulse |
| progMsb | input | 1 | Bit 7 of the byte being programmed |
| opFail | input | 1 | Operation failure pulse |
| opDone | input | 1 | Successful completion pulse |
| resetCmd | input | 1 | Reset command pulse |
| arrayData | input | 8 | Array data for pass-through reads |
| statusOut | output | 8 | Read data / status word |
| ready | output | 1 | High when no operation is running |

## Verification
A behavioural model is compared with every output on every cycle. The stimulus covers program with both values of the programmed bit, which separates the complement poll from a pass-through. Erase reads alternate between masked and unmasked blocks, which separates the two toggle bits. Suspend reads also switch between blocks, so status output and array pass-through are told apart. A chip-erase failure followed by a reset command shows that the mask is retained and then cleared. Window tests count cycles with and without a restarting confirm, which pins down the load value and the restart behaviour.

// File: rtl/pe_status_pkg.sv
package pe_status_pkg;

  typedef enum logic [2:0] {
    OP_IDLE      = 3'd0,
    OP_PROG      = 3'd1,
    OP_ERASE     = 3'd2,
    OP_SUSP      = 3'd3,
    OP_SUSP_PROG = 3'd4
  } opState_e;

  typedef enum logic [2:0] {
    SEL_ARRAY,
    SEL_PROG,
    SEL_ERASE,
    SEL_SUSP_HIT,
    SEL_FAIL
  } outSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic    advTog6;
    logic    advTog2;
    logic    latchBlk;
    logic    loadWin;
    logic    clrWin;
    logic    addBlk;
    logic    allBlk;
    logic    clrMask;
    logic    setErr;
    logic    clrErr;
    outSel_e sel;
  } dpCtrl_t;

endpackage

// File: rtl/pe_status_ctrl.sv
module pe_status_ctrl
  import pe_status_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] opState,
  input  logic       rdStrobe,
  input  logic       eraseConfirm,
  input  logic       chipErase,
  input  logic       opFail,
  input  logic       opDone,
  input  logic       resetCmd,
  input  logic       hitNow,
  input  logic       hitLatched,
  input  logic       errQ,
  output dpCtrl_t    ctrl,
  output logic       ready
);

  opState_e st;
  logic     rdPrev;
  logic     readFall;
  logic     isIdle;
  logic     tog2Gate;

  assign st = opState_e'(opState);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdPrev <= 1'b0;
    else       rdPrev <= rdStrobe;
  end

  assign readFall = rdPrev && !rdStrobe;

  always_comb begin
    isIdle = 1'b1;
    case (st)
      OP_PROG, OP_ERASE, OP_SUSP, OP_SUSP_PROG: isIdle = 1'b0;
      default:                                  isIdle = 1'b1;
    endcase
  end

  assign tog2Gate = (st == OP_ERASE) || (st == OP_SUSP) || (isIdle && errQ);

  always_comb begin
    ctrl          = '0;
    ctrl.advTog6  = readFall;
    ctrl.advTog2  = readFall && hitLatched && tog2Gate;
    ctrl.latchBlk = rdStrobe;
    ctrl.loadWin  = (eraseConfirm || chipErase) && !resetCmd;
    ctrl.clrWin   = resetCmd;
    ctrl.addBlk   = eraseConfirm;
    ctrl.allBlk   = chipErase;
    ctrl.clrMask  = resetCmd || (opDone && st == OP_ERASE);
    ctrl.setErr   = opFail && !resetCmd;
    ctrl.clrErr   = resetCmd || opDone;
    case (st)
      OP_PROG, OP_SUSP_PROG: ctrl.sel = SEL_PROG;
      OP_ERASE:              ctrl.sel = SEL_ERASE;
      OP_SUSP:               ctrl.sel = hitNow ? SEL_SUSP_HIT : SEL_ARRAY;
      default:               ctrl.sel = errQ ? SEL_FAIL : SEL_ARRAY;
    endcase
  end

  always_comb begin
    case (st)
      OP_PROG, OP_ERASE, OP_SUSP_PROG: ready = 1'b0;
      default:                         ready = 1'b1;
    endcase
  end

endmodule

// File: rtl/pe_status_dp.sv
module pe_status_dp
  import pe_status_pkg::*;
#(
  parameter int NUM_BLK = 8,
  parameter int WINDOW  = 100,
  localparam int BLK_W  = $clog2(NUM_BLK),
  localparam int WIN_W  = $clog2(WINDOW + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtrl_t          ctrl,
  input  logic [BLK_W-1:0] rdBlk,
  input  logic [BLK_W-1:0] eraseBlk,
  input  logic             progMsb,
  input  logic [7:0]       arrayData,
  output logic [7:0]       statusOut,
  output logic             hitNow,
  output logic             hitLatched,
  output logic             errQ,
  output logic             winIdle,
  output logic             tog6Q,
  output logic             tog2Q
);

  localparam logic [WIN_W-1:0] WIN_LOAD = WIN_W'(WINDOW);

  logic [NUM_BLK-1:0] eraseMask;
  logic [BLK_W-1:0]   blkQ;
  logic [WIN_W-1:0]   winCnt;
  logic               bit2Sel;

  // per-block erase flags
  for (genvar b = 0; b < NUM_BLK; b++) begin : g_blk
    logic blkBit;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                     blkBit <= 1'b0;
      else if (ctrl.clrMask)         blkBit <= 1'b0;
      else if (ctrl.allBlk ||
               (ctrl.addBlk && eraseBlk == BLK_W'(b)))
                                     blkBit <= 1'b1;
    end
    assign eraseMask[b] = blkBit;
  end

  assign hitNow     = eraseMask[rdBlk];
  assign hitLatched = eraseMask[blkQ];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              blkQ <= '0;
    else if (ctrl.latchBlk) blkQ <= rdBlk;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tog6Q <= 1'b0;
      tog2Q <= 1'b0;
    end else begin
      if (ctrl.advTog6) tog6Q <= ~tog6Q;
      if (ctrl.advTog2) tog2Q <= ~tog2Q;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             errQ <= 1'b0;
    else if (ctrl.setErr)  errQ <= 1'b1;
    else if (ctrl.clrErr)  errQ <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                winCnt <= '0;
    else if (ctrl.clrWin)     winCnt <= '0;
    else if (ctrl.loadWin)    winCnt <= WIN_LOAD;
    else if (winCnt != '0)    winCnt <= winCnt - 1'b1;
  end

  assign winIdle = (winCnt == '0);
  assign bit2Sel = hitNow ? tog2Q : 1'b1;

  always_comb begin
    case (ctrl.sel)
      SEL_PROG:     statusOut = {~progMsb, tog6Q, errQ, 1'b0, winIdle, 1'b1, 2'b00};
      SEL_ERASE:    statusOut = {1'b0, tog6Q, errQ, 1'b0, winIdle, bit2Sel, 2'b00};
      SEL_SUSP_HIT: statusOut = {2'b11, errQ, 1'b0, winIdle, tog2Q, 2'b00};
      SEL_FAIL:     statusOut = {1'b0, tog6Q, 1'b1, 1'b0, winIdle, bit2Sel, 2'b00};
      default:      statusOut = arrayData;
    endcase
  end

endmodule

// File: rtl/pe_status_poll.sv
module pe_status_poll
  import pe_status_pkg::*;
#(
  parameter int NUM_BLK = 8,
  parameter int WINDOW  = 100,
  localparam int BLK_W  = $clog2(NUM_BLK)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [2:0]       opState,
  input  logic             rdStrobe,
  input  logic [BLK_W-1:0] rdBlk,
  input  logic             eraseConfirm,
  input  logic [BLK_W-1:0] eraseBlk,
  input  logic             chipErase,
  input  logic             progMsb,
  input  logic             opFail,
  input  logic             opDone,
  input  logic             resetCmd,
  input  logic [7:0]       arrayData,
  output logic [7:0]       statusOut,
  output logic             ready
);

  dpCtrl_t ctrl;
  logic    hitNow;
  logic    hitLatched;
  logic    errQ;
  logic    winIdle;
  logic    tog6Q;
  logic    tog2Q;

  pe_status_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .opState      (opState),
    .rdStrobe     (rdStrobe),
    .eraseConfirm (eraseConfirm),
    .chipErase    (chipErase),
    .opFail       (opFail),
    .opDone       (opDone),
    .resetCmd     (resetCmd),
    .hitNow       (hitNow),
    .hitLatched   (hitLatched),
    .errQ         (errQ),
    .ctrl         (ctrl),
    .ready        (ready)
  );

  pe_status_dp #(
    .NUM_BLK (NUM_BLK),
    .WINDOW  (WINDOW)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctrl       (ctrl),
    .rdBlk      (rdBlk),
    .eraseBlk   (eraseBlk),
    .progMsb    (progMsb),
    .arrayData  (arrayData),
    .statusOut  (statusOut),
    .hitNow     (hitNow),
    .hitLatched (hitLatched),
    .errQ       (errQ),
    .winIdle    (winIdle),
    .tog6Q      (tog6Q),
    .tog2Q      (tog2Q)
  );

endmodule

// File: rtl/pe_status_poll_chk.sv
module pe_status_poll_chk
  import pe_status_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic [2:0] opState,
  input logic       rdStrobe,
  input logic       eraseConfirm,
  input logic       opFail,
  input logic       resetCmd,
  input logic [7:0] statusOut,
  input logic       ready,
  input logic       errQ,
  input logic       winIdle,
  input logic       tog6Q,
  input logic       hitNow
);

  assert_busy_R10: assert property (@(posedge clk) disable iff (!rstN)
    (opState == OP_PROG || opState == OP_ERASE || opState == OP_SUSP_PROG) |-> !ready);

  assert_susp_ready_R4: assert property (@(posedge clk) disable iff (!rstN)
    (opState == OP_SUSP) |-> ready);

  assert_susp_hit_R4: assert property (@(posedge clk) disable iff (!rstN)
    (opState == OP_SUSP && hitNow) |-> (statusOut[7:6] == 2'b11));

  assert_prog_bits_R1: assert property (@(posedge clk) disable iff (!rstN)
    (opState == OP_PROG) |-> (statusOut[2] && !statusOut[4]));

  assert_err_set_R6: assert property (@(posedge clk) disable iff (!rstN)
    (opFail && !resetCmd) |=> errQ);

  assert_err_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    resetCmd |=> !errQ);

  assert_win_open_R8: assert property (@(posedge clk) disable iff (!rstN)
    (eraseConfirm && !resetCmd) |=> !winIdle);

  assert_tog_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    rdStrobe |=> $stable(tog6Q));

endmodule

bind pe_status_poll pe_status_poll_chk u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .opState      (opState),
  .rdStrobe     (rdStrobe),
  .eraseConfirm (eraseConfirm),
  .opFail       (opFail),
  .resetCmd     (resetCmd),
  .statusOut    (statusOut),
  .ready        (ready),
  .errQ         (errQ),
  .winIdle      (winIdle),
  .tog6Q        (tog6Q),
  .hitNow       (hitNow)
);

// File: tb/pe_status_poll_bench.sv
`timescale 1ns/1ps
module pe_status_poll_bench;

  localparam int NUM_BLK = 8;
  localparam int BLK_W   = 3;
  localparam int WINDOW  = 6;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [2:0]       opState = 3'd0;
  logic             rdStrobe = 1'b0;
  logic [BLK_W-1:0] rdBlk = '0;
  logic             eraseConfirm = 1'b0;
  logic [BLK_W-1:0] eraseBlk = '0;
  logic             chipErase = 1'b0;
  logic             progMsb = 1'b0;
  logic             opFail = 1'b0;
  logic             opDone = 1'b0;
  logic             resetCmd = 1'b0;
  logic [7:0]       arrayData = 8'h3C;
  logic [7:0]       statusOut;
  logic             ready;

  int    nChecks = 0;
  int    nFails  = 0;
  string phase   = "R11";
  bit    finished = 1'b0;

  // behavioural reference state
  bit               mTog6, mTog2, mErr, mPrev;
  bit [NUM_BLK-1:0] mMask;
  int               mBlkQ, mWin;

  always #10 clk = ~clk;

  pe_status_poll #(.NUM_BLK(NUM_BLK), .WINDOW(WINDOW)) u_pe_status_poll (
    .clk(clk), .rstN(rstN), .opState(opState), .rdStrobe(rdStrobe),
    .rdBlk(rdBlk), .eraseConfirm(eraseConfirm), .eraseBlk(eraseBlk),
    .chipErase(chipErase), .progMsb(progMsb), .opFail(opFail),
    .opDone(opDone), .resetCmd(resetCmd), .arrayData(arrayData),
    .statusOut(statusOut), .ready(ready)
  );

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mTog6 = 0; mTog2 = 0; mErr = 0; mPrev = 0; mMask = '0; mBlkQ = 0; mWin = 0;
    end else begin
      bit idleLike;
      idleLike = !(opState inside {3'd1, 3'd2, 3'd3, 3'd4});
      if (mPrev && !rdStrobe) begin
        mTog6 = !mTog6;
        if (mMask[mBlkQ] && (opState == 3'd2 || opState == 3'd3 || (idleLike && mErr)))
          mTog2 = !mTog2;
      end
      if (rdStrobe) mBlkQ = int'(rdBlk);
      mPrev = rdStrobe;
      if (resetCmd) mErr = 0;
      else if (opFail) mErr = 1;
      else if (opDone) mErr = 0;
      if (resetCmd || (opDone && opState == 3'd2)) mMask = '0;
      else begin
        if (chipErase) mMask = '1;
        if (eraseConfirm) mMask[eraseBlk] = 1'b1;
      end
      if (resetCmd) mWin = 0;
      else if (eraseConfirm || chipErase) mWin = WINDOW;
      else if (mWin > 0) mWin = mWin - 1;
    end
  end

  function automatic logic [7:0] expStatus();
    bit hit = mMask[rdBlk];
    bit win = (mWin == 0);
    bit b2  = hit ? mTog2 : 1'b1;
    case (opState)
      3'd1, 3'd4: return {~progMsb, mTog6, mErr, 1'b0, win, 1'b1, 2'b00};
      3'd2:       return {1'b0, mTog6, mErr, 1'b0, win, b2, 2'b00};
      3'd3:       return hit ? {2'b11, mErr, 1'b0, win, mTog2, 2'b00} : arrayData;
      default:    return mErr ? {1'b0, mTog6, 1'b1, 1'b0, win, b2, 2'b00} : arrayData;
    endcase
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one clock; compare at the falling edge before new inputs are applied
  task automatic cyc();
    @(negedge clk);
    if (rstN) begin
      chk(phase, statusOut, expStatus());
      chk({phase, "/R10"}, {7'd0, ready}, {7'd0, !(opState inside {3'd1, 3'd2, 3'd4})});
    end
  endtask

  task automatic doRead(input int blk, output logic [7:0] s);
    rdBlk = BLK_W'(blk); rdStrobe = 1'b1;
    cyc();
    s = statusOut;
    cyc();
    rdStrobe = 1'b0;
    cyc();
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    nFails++;
    $display("FAIL watchdog expired (all requirements)");
    summary();
  end

  initial begin
    logic [7:0] s1, s2;
    int k;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    cyc();
    phase = "R11";
    chk("R11 reset output", statusOut, 8'h3C);
    chk("R11 reset ready", {7'd0, ready}, 8'd1);

    // program, both polarities of the programmed bit
    phase = "R1"; opState = 3'd1; progMsb = 1'b1;
    doRead(1, s1); doRead(1, s2);
    chk("R1 poll bit", {7'd0, s1[7]}, 8'd0);
    chk("R9 back-to-back bit6", {7'd0, s1[6] ^ s2[6]}, 8'd1);
    progMsb = 1'b0;
    doRead(4, s1);
    chk("R1 poll bit low data", {7'd0, s1[7]}, 8'd1);
    chk("R1 bit2 one", {7'd0, s1[2]}, 8'd1);

    // erase window timing
    phase = "R8"; opState = 3'd2;
    eraseConfirm = 1'b1; eraseBlk = 3'd2; cyc(); eraseConfirm = 1'b0;
    chk("R8 window closed", {7'd0, statusOut[3]}, 8'd0);
    k = 0;
    while (statusOut[3] == 1'b0 && k < 100) begin cyc(); k++; end
    chk("R8 window length", 8'(k), 8'(WINDOW));
    eraseConfirm = 1'b1; eraseBlk = 3'd5; cyc(); eraseConfirm = 1'b0;
    repeat (3) cyc();
    eraseConfirm = 1'b1; eraseBlk = 3'd5; cyc(); eraseConfirm = 1'b0;
    k = 0;
    while (statusOut[3] == 1'b0 && k < 100) begin cyc(); k++; end
    chk("R8 window restart length", 8'(k), 8'(WINDOW));

    // erase reads, masked and unmasked blocks
    phase = "R2";
    doRead(2, s1); doRead(2, s2);
    chk("R2 bit2 toggles in masked block", {7'd0, s1[2] ^ s2[2]}, 8'd1);
    chk("R2 bit7 zero", {7'd0, s1[7]}, 8'd0);
    doRead(0, s1);
    chk("R2 bit2 one outside mask", {7'd0, s1[2]}, 8'd1);
    doRead(5, s1); doRead(0, s1); doRead(5, s2);

    // suspend
    phase = "R4"; opState = 3'd3;
    doRead(2, s1);
    chk("R4 suspend hit bits", {6'd0, s1[7:6]}, 8'd3);
    doRead(0, s1);
    chk("R4 suspend miss array", s1, 8'h3C);
    arrayData = 8'hA5; doRead(6, s1); doRead(5, s2);

    phase = "R5"; opState = 3'd4; progMsb = 1'b1;
    doRead(0, s1); doRead(0, s2);
    chk("R5 poll bit", {7'd0, s1[7]}, 8'd0);

    // successful erase completion clears mask
    phase = "R2"; opState = 3'd2;
    opDone = 1'b1; cyc(); opDone = 1'b0;
    opState = 3'd0; cyc();
    doRead(2, s1);
    chk("R2 mask cleared on done", s1, 8'hA5);

    // program failure then reset
    phase = "R6"; opState = 3'd1;
    opFail = 1'b1; cyc(); opFail = 1'b0;
    opState = 3'd0; doRead(1, s1);
    chk("R6 error bit", {7'd0, s1[5]}, 8'd1);
    resetCmd = 1'b1; opFail = 1'b1; cyc(); resetCmd = 1'b0; opFail = 1'b0;
    doRead(1, s1);
    chk("R6 reset priority", s1, 8'hA5);

    // chip erase with failure
    phase = "R3"; opState = 3'd2;
    chipErase = 1'b1; cyc(); chipErase = 1'b0;
    doRead(7, s1); doRead(3, s2);
    chk("R3 bit2 toggles any block", {7'd0, s1[2] ^ s2[2]}, 8'd1);
    phase = "R7";
    opFail = 1'b1; cyc(); opFail = 1'b0; opState = 3'd0;
    doRead(4, s1); doRead(4, s2);
    chk("R7 faulty block toggle", {7'd0, s1[2] ^ s2[2]}, 8'd1);
    chk("R7 error shown", {7'd0, s2[5]}, 8'd1);
    resetCmd = 1'b1; cyc(); resetCmd = 1'b0;
    doRead(4, s1);
    chk("R7 reset restores array", s1, 8'hA5);

    // error cleared by a later success
    phase = "R6"; opState = 3'd1;
    opFail = 1'b1; cyc(); opFail = 1'b0;
    opDone = 1'b1; cyc(); opDone = 1'b0;
    doRead(0, s1);
    chk("R6 cleared by done", {7'd0, s1[5]}, 8'd0);
    opState = 3'd0; cyc();
    summary();
  end

endmodule